// File: doc/BRIEF.md
# Opcode Fetch Integrity Guard

This block sits between the instruction fetch stage and the decoder. Every fetched opcode arrives with one stored check bit, chosen so that the opcode and that bit together hold an even number of ones. The guard checks that bit and also checks whether the opcode belongs to the defined instruction set. Each accepted word gets exactly one of three outcomes, one clock after it arrives. A word that passes both checks goes to decode. A word with broken parity produces a flush and a request to fetch the same address again. A word with good parity but an undefined opcode raises an illegal-instruction trap.

Flipping one bit always breaks parity, so single faults lead to a re-fetch. Flipping two bits keeps parity even, so the parity check misses them. Because the defined opcodes are spread sparsely over the 6-bit space, many double faults land on an undefined pattern and raise a trap instead. The guard also counts repeated parity failures at one address. This stops a stuck fault from causing re-fetches forever: at the retry limit the guard traps. It does not correct faults.

Top module: `opcode_fetch_guard`

## Requirements
- R1: While reset is held and through the reset release, `dec_valid`, `refetch_req` and `illegal_trap` are all low.
- R2: A word accepted with `fetch_valid` high is forwarded when it has even parity and its opcode is one of the twelve defined codes. The defined codes are 0x01, 0x06, 0x0B, 0x10, 0x17, 0x1A, 0x24, 0x29, 0x2E, 0x33, 0x38 and 0x3D. Forwarding means `dec_valid` is high one cycle later and `dec_opcode` equals the accepted opcode.
- R3: An accepted word has bad parity when its 6 opcode bits plus `fetch_parity` hold an odd number of ones. Such a word produces a `refetch_req` pulse one cycle later, lasting one cycle, with `refetch_addr` equal to the word's `fetch_addr`. The only exception is the case in R7.
- R4: An accepted word with even parity and an opcode outside the defined set raises `illegal_trap` for one cycle, one cycle later.
- R5: A word with bad parity never raises `illegal_trap` on its own account, even if its opcode is undefined. Parity takes priority over the legality check.
- R6: In any cycle where `refetch_req` or `illegal_trap` is high, `dec_valid` is low.
- R7: The third consecutive parity failure at the same address raises `illegal_trap` instead of `refetch_req`, and it clears the failure count. Cycles with `fetch_valid` low do not break the run.
- R8: An accepted word with good parity, or a parity failure at a different address, restarts the failure count. The restarted count is 0 after a good word and 1 after a failure at a new address.
- R9: In a cycle where `fetch_valid` is low, the opcode, parity and address inputs have no effect: the next cycle shows no `dec_valid`, `refetch_req` or `illegal_trap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fetch_valid | input | 1 | A fetched word is present this cycle |
| fetch_opcode | input | 6 | Fetched opcode |
| fetch_parity | input | 1 | Stored even-parity bit for the opcode |
| fetch_addr | input | 32 | Address the word was fetched from |
| dec_valid | output | 1 | Forwarded opcode is valid for decode |
| dec_opcode | output | 6 | Forwarded opcode |
| refetch_req | output | 1 | One-cycle flush and re-fetch request |
| refetch_addr | output | 32 | Address to fetch again |
| illegal_trap | output | 1 | One-cycle illegal-instruction trap |

## Verification
All 64 opcodes are sent with correct parity, which separates the defined set from the undefined patterns. Each defined opcode is then sent again with one bit flipped and with the check bit flipped. These cases separate parity detection from legality decoding. Two-bit flips of defined opcodes show which double faults the guard can still catch as traps. Runs of failures at one address, at alternating addresses, broken by good words and spaced by idle cycles, test the retry count, where it restarts and the point where it switches to a trap.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int FG_OP_W    = 6;
  localparam int FG_NUM_OPS = 12;

  // Defined instruction set: sparse within the 6-bit space
  localparam logic [FG_OP_W-1:0] FG_OPS [FG_NUM_OPS] = '{
    6'h01, 6'h06, 6'h0B, 6'h10, 6'h17, 6'h1A,
    6'h24, 6'h29, 6'h2E, 6'h33, 6'h38, 6'h3D
  };

  typedef enum logic [1:0] {
    FG_PASS   = 2'd0,
    FG_FLUSH  = 2'd1,
    FG_TRAP   = 2'd2,
    FG_NONE   = 2'd3
  } fg_verdict_e;
endpackage

// File: rtl/fg_parity_chk.sv
module fg_parity_chk #(
  parameter int DATA_W = 6
) (
  input  logic [DATA_W-1:0] data,
  input  logic              chk_bit,
  output logic              par_err
);
  // Even sense: data plus check bit must hold an even count of ones
  always_comb begin
    par_err = chk_bit;
    for (int i = 0; i < DATA_W; i++) begin
      par_err = par_err ^ data[i];
    end
  end
endmodule

// File: rtl/fg_legal_dec.sv
module fg_legal_dec
  import fg_pkg::*;
#(
  parameter int OP_W   = FG_OP_W,
  parameter int NUM_OP = FG_NUM_OPS
) (
  input  logic [OP_W-1:0] opcode,
  output logic            legal
);
  logic [NUM_OP-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_OP; g++) begin : g_match
      assign hit[g] = (opcode == FG_OPS[g]);
    end
  endgenerate

  assign legal = |hit;
endmodule

// File: rtl/fg_retry_ctr.sv
module fg_retry_ctr #(
  parameter int ADDR_W    = 32,
  parameter int RETRY_MAX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fail,
  input  logic              clean,
  input  logic [ADDR_W-1:0] addr,
  output logic              at_limit
);
  localparam int CNT_W = $clog2(RETRY_MAX + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RETRY_MAX);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_run;
  logic [ADDR_W-1:0] last_q, last_d;
  logic              same_addr;
  logic              last_en;

  assign same_addr = (cnt_q != '0) && (addr == last_q);
  assign cnt_run   = same_addr ? (cnt_q + ONE) : ONE;
  assign at_limit  = fail && (cnt_run == LIMIT);

  always_comb begin
    cnt_d   = cnt_q;
    last_d  = last_q;
    last_en = 1'b0;
    if (fail) begin
      last_en = 1'b1;
      last_d  = addr;
      cnt_d   = at_limit ? '0 : cnt_run;
    end else if (clean) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (last_en) begin
        last_q <= last_d;
      end
    end
  end
endmodule

// File: rtl/opcode_fetch_guard.sv
module opcode_fetch_guard
  import fg_pkg::*;
#(
  parameter int OP_W      = FG_OP_W,
  parameter int ADDR_W    = 32,
  parameter int RETRY_MAX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [OP_W-1:0]   fetch_opcode,
  input  logic              fetch_parity,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              dec_valid,
  output logic [OP_W-1:0]   dec_opcode,
  output logic              refetch_req,
  output logic [ADDR_W-1:0] refetch_addr,
  output logic              illegal_trap
);
  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic par_err, legal, at_limit;
  logic fail, clean;
  fg_verdict_e verdict;

  fg_parity_chk #(.DATA_W(OP_W)) u_par (
    .data    (fetch_opcode),
    .chk_bit (fetch_parity),
    .par_err (par_err)
  );

  fg_legal_dec #(.OP_W(OP_W), .NUM_OP(FG_NUM_OPS)) u_legal (
    .opcode (fetch_opcode),
    .legal  (legal)
  );

  assign fail  = fetch_valid &  par_err;
  assign clean = fetch_valid & ~par_err;

  fg_retry_ctr #(.ADDR_W(ADDR_W), .RETRY_MAX(RETRY_MAX)) u_retry (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .fail     (fail),
    .clean    (clean),
    .addr     (fetch_addr),
    .at_limit (at_limit)
  );

  // Parity is judged first; legality only for parity-clean words
  always_comb begin
    if (!fetch_valid)  verdict = FG_NONE;
    else if (par_err)  verdict = at_limit ? FG_TRAP : FG_FLUSH;
    else if (!legal)   verdict = FG_TRAP;
    else               verdict = FG_PASS;
  end

  logic              dv_d, rf_d, tr_d;
  logic              op_en, addr_en;
  logic              dv_q, rf_q, tr_q;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    dv_d    = (verdict == FG_PASS);
    rf_d    = (verdict == FG_FLUSH);
    tr_d    = (verdict == FG_TRAP);
    op_en   = dv_d;
    addr_en = rf_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dv_q   <= 1'b0;
      rf_q   <= 1'b0;
      tr_q   <= 1'b0;
      op_q   <= '0;
      addr_q <= '0;
    end else begin
      dv_q <= dv_d;
      rf_q <= rf_d;
      tr_q <= tr_d;
      if (op_en) begin
        op_q <= fetch_opcode;
      end
      if (addr_en) begin
        addr_q <= fetch_addr;
      end
    end
  end

  assign dec_valid    = dv_q;
  assign dec_opcode   = op_q;
  assign refetch_req  = rf_q;
  assign refetch_addr = addr_q;
  assign illegal_trap = tr_q;
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int OP_W   = 6,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [OP_W-1:0]   fetch_opcode,
  input logic              fetch_parity,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              dec_valid,
  input logic [OP_W-1:0]   dec_opcode,
  input logic              refetch_req,
  input logic [ADDR_W-1:0] refetch_addr,
  input logic              illegal_trap
);
  AST_NO_DECODE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (refetch_req || illegal_trap) |-> !dec_valid); // R6

  AST_FLUSH_TRAP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(refetch_req && illegal_trap)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !(dec_valid || refetch_req || illegal_trap)); // R9

  AST_BAD_PAR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && ^{fetch_opcode, fetch_parity}) |=>
      (refetch_req ? (refetch_addr == $past(fetch_addr)) : illegal_trap)); // R3

  AST_BAD_PAR_NO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && ^{fetch_opcode, fetch_parity}) |=> !dec_valid); // R5

  AST_CLEAN_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !(^{fetch_opcode, fetch_parity})) |=> !refetch_req); // R3

  AST_CLEAN_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !(^{fetch_opcode, fetch_parity})) |=>
      (dec_valid ? (dec_opcode == $past(fetch_opcode)) : illegal_trap)); // R2
endmodule

bind opcode_fetch_guard fg_checker #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_fg_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .fetch_valid  (fetch_valid),
  .fetch_opcode (fetch_opcode),
  .fetch_parity (fetch_parity),
  .fetch_addr   (fetch_addr),
  .dec_valid    (dec_valid),
  .dec_opcode   (dec_opcode),
  .refetch_req  (refetch_req),
  .refetch_addr (refetch_addr),
  .illegal_trap (illegal_trap)
);

// File: tb/sim_opcode_fetch_guard.sv
module sim_opcode_fetch_guard;
  logic        clk;
  logic        rst_n;
  logic        fetch_valid;
  logic [5:0]  fetch_opcode;
  logic        fetch_parity;
  logic [31:0] fetch_addr;
  logic        dec_valid;
  logic [5:0]  dec_opcode;
  logic        refetch_req;
  logic [31:0] refetch_addr;
  logic        illegal_trap;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    chk_on  = 0;
  bit    done    = 0;
  string tag     = "R1";

  opcode_fetch_guard u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .fetch_opcode (fetch_opcode),
    .fetch_parity (fetch_parity),
    .fetch_addr   (fetch_addr),
    .dec_valid    (dec_valid),
    .dec_opcode   (dec_opcode),
    .refetch_req  (refetch_req),
    .refetch_addr (refetch_addr),
    .illegal_trap (illegal_trap)
  );

  // 200 MHz
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit is_defined(input logic [5:0] op);
    case (op)
      6'h01, 6'h06, 6'h0B, 6'h10, 6'h17, 6'h1A,
      6'h24, 6'h29, 6'h2E, 6'h33, 6'h38, 6'h3D: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic good_par(input logic [5:0] op);
    return ^op;
  endfunction

  task automatic check(input string name, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  // Reference model: behavioural, state kept in integers
  int          m_cnt = 0;
  logic [31:0] m_last = 0;
  bit          e_valid, e_ref, e_trap;
  logic [5:0]  e_op;
  logic [31:0] e_addr;

  always @(posedge clk) begin
    bit bad;
    if (!rst_n) begin
      m_cnt = 0; m_last = 0;
      e_valid = 0; e_ref = 0; e_trap = 0;
    end else begin
      e_valid = 0; e_ref = 0; e_trap = 0;
      if (fetch_valid) begin
        bad = ((^fetch_opcode) != fetch_parity);
        if (bad) begin
          if (m_cnt > 0 && m_last == fetch_addr) m_cnt = m_cnt + 1;
          else m_cnt = 1;
          m_last = fetch_addr;
          if (m_cnt >= 3) begin
            e_trap = 1; m_cnt = 0;                 // R7
          end else begin
            e_ref = 1; e_addr = fetch_addr;        // R3
          end
        end else begin
          m_cnt = 0;                               // R8
          if (is_defined(fetch_opcode)) begin
            e_valid = 1; e_op = fetch_opcode;      // R2
          end else begin
            e_trap = 1;                            // R4
          end
        end
      end
    end
    #1;
    if (chk_on && !done) begin
      check("dec_valid", 32'(dec_valid), 32'(e_valid));
      check("refetch_req", 32'(refetch_req), 32'(e_ref));
      check("illegal_trap", 32'(illegal_trap), 32'(e_trap));
      if (e_valid) check("dec_opcode", 32'(dec_opcode), 32'(e_op));
      if (e_ref)   check("refetch_addr", refetch_addr, e_addr);
    end
  end

  task automatic put(input bit v, input logic [5:0] op, input logic par, input logic [31:0] a);
    @(negedge clk);
    fetch_valid  = v;
    fetch_opcode = op;
    fetch_parity = par;
    fetch_addr   = a;
  endtask

  task automatic idle();
    put(1'b0, 6'h3F, 1'b1, 32'hDEAD_BEEF);  // R9: garbage on idle inputs
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<20000", wd);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    fetch_valid = 1'b0; fetch_opcode = '0; fetch_parity = 1'b0; fetch_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    check("dec_valid", 32'(dec_valid), 0);
    check("refetch_req", 32'(refetch_req), 0);
    check("illegal_trap", 32'(illegal_trap), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    chk_on = 1;   // R1: idle outputs compared during release as well
    repeat (2) idle();

    // R2 / R4: every opcode with correct parity
    for (int i = 0; i < 64; i++) begin
      tag = is_defined(6'(i)) ? "R2" : "R4";
      put(1'b1, 6'(i), good_par(6'(i)), 32'h1000 + 32'(i) * 4);
    end
    idle();

    // R3: single flips of defined opcodes, and of the check bit
    tag = "R3";
    for (int i = 0; i < 64; i++) begin
      if (is_defined(6'(i))) begin
        for (int b = 0; b < 6; b++) begin
          logic [5:0] f;
          f = 6'(i) ^ (6'(1) << b);
          put(1'b1, f, good_par(6'(i)), 32'h2000 + 32'(i * 8 + b));
          put(1'b1, 6'(i), good_par(6'(i)), 32'h2000 + 32'(i * 8 + b));  // clean retry
        end
        put(1'b1, 6'(i), ~good_par(6'(i)), 32'h2400 + 32'(i));
        idle();
      end
    end

    // R5: undefined opcode with bad parity re-fetches, never traps
    tag = "R5";
    put(1'b1, 6'h00, 1'b1, 32'h3000);
    put(1'b1, 6'h3F, 1'b1, 32'h3004);
    put(1'b1, 6'h3E, 1'b0, 32'h3008);
    idle();

    // R4: double flips of defined opcodes, parity stays even
    tag = "R4";
    for (int b0 = 0; b0 < 6; b0++) begin
      for (int b1 = b0 + 1; b1 < 6; b1++) begin
        logic [5:0] f;
        f = 6'h17 ^ (6'(1) << b0) ^ (6'(1) << b1);
        put(1'b1, f, good_par(6'h17), 32'h3100 + 32'(b0 * 8 + b1));
      end
    end
    idle();

    // R6: mixed back-to-back stream, fault cycles show no decode
    tag = "R6";
    put(1'b1, 6'h29, good_par(6'h29), 32'h3200);
    put(1'b1, 6'h29, ~good_par(6'h29), 32'h3204);
    put(1'b1, 6'h02, good_par(6'h02), 32'h3208);
    put(1'b1, 6'h38, good_par(6'h38), 32'h320C);
    idle();

    // R7: three failures at one address, idle gaps in between
    tag = "R7";
    put(1'b1, 6'h10, 1'b0, 32'h4000); idle();
    put(1'b1, 6'h10, 1'b0, 32'h4000); idle(); idle();
    put(1'b1, 6'h10, 1'b0, 32'h4000);            // trap
    put(1'b1, 6'h10, 1'b0, 32'h4000);            // count restarted: re-fetch
    put(1'b1, 6'h10, 1'b0, 32'h4000);
    put(1'b1, 6'h10, 1'b0, 32'h4000);            // trap again
    idle();

    // R8: good word or new address restarts the count
    tag = "R8";
    put(1'b1, 6'h24, 1'b1, 32'h5000);
    put(1'b1, 6'h24, 1'b1, 32'h5000);
    put(1'b1, 6'h24, 1'b0, 32'h5000);            // clean
    put(1'b1, 6'h24, 1'b1, 32'h5000);            // count 1
    put(1'b1, 6'h24, 1'b1, 32'h5000);            // count 2
    put(1'b1, 6'h24, 1'b1, 32'h5040);            // new address, count 1
    put(1'b1, 6'h24, 1'b1, 32'h5040);
    put(1'b1, 6'h24, 1'b1, 32'h5040);            // trap
    put(1'b1, 6'h24, 1'b1, 32'h5000);
    put(1'b1, 6'h24, 1'b1, 32'h5040);
    put(1'b1, 6'h24, 1'b1, 32'h5000);            // alternating: no trap
    idle();

    // R9: long idle run with changing garbage
    tag = "R9";
    for (int i = 0; i < 8; i++) put(1'b0, 6'(i * 7), 1'(i), 32'(i));
    idle(); idle();
    finish_run();
  end
endmodule